// File: doc/BRIEF.md
# Sub-word load/store lane aligner

This block sits between a core's load/store path and a data memory that is byte-addressed but read and written one full word at a time. On a load it takes the fetched memory word and picks the addressed byte or halfword. It moves that value into the low bits of the result and fills the upper bits with either copies of its top bit or zeros. On a store it places the low byte or low halfword of the source register on every matching lane of the write bus. It then drives a per-byte write-enable mask so that only the addressed bytes change in memory.

The access size and the low address bits decide which lanes are used. Lanes are big-endian: the byte at address offset 0 sits in the most significant byte of the memory word. The size code is 00 for byte, 01 for halfword and 10 for word, and 11 is reserved. A halfword access at an odd address, a word access at an address that is not a multiple of four, and any access with the reserved code all raise a misalignment flag. Such an access writes nothing and returns no load data. The store path is combinational. The load result passes through one output register by default, and a parameter can remove it.

Top module: `ldst_lane_align`

## Requirements
- R1: A byte load at address offset k (0..3) returns memory bits [31-8k : 24-8k] in load_data_o[7:0], so offset 0 selects bits 31:24 and offset 3 selects bits 7:0.
- R2: A halfword load at offset 0 returns memory bits 31:16 and at offset 2 returns bits 15:0, in load_data_o[15:0].
- R3: With unsigned_i low, a byte or halfword load fills the upper bits of load_data_o with the top bit of the selected value. With unsigned_i high, it fills them with zeros.
- R4: An aligned word load (size 10, offset 0) returns the memory word unchanged.
- R5: With the default output register, load_data_o and load_valid_o reflect the request of the previous clock cycle. load_valid_o is high exactly after an aligned load, and reset clears both outputs to zero.
- R6: On an aligned store, mem_wdata_o carries four copies of wdata_i[7:0] for a byte, two copies of wdata_i[15:0] for a halfword, and wdata_i for a word.
- R7: mem_be_o bit 3 enables bits 31:24 and bit 0 enables bits 7:0. An aligned byte store enables only bit (3-offset), a halfword store enables 4'b1100 at offset 0 and 4'b0011 at offset 2, and a word store enables 4'b1111. mem_be_o is zero whenever store_i is low.
- R8: misalign_o is high, in the same cycle, when load_i or store_i is high and the access is one of these: size 01 with address bit 0 set, size 10 with either low address bit set, or size 11. A byte access never raises it.
- R9: A misaligned store drives mem_be_o to zero. After a misaligned load or a cycle with no load, load_valid_o is low and load_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the load output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 reserved |
| unsigned_i | input | 1 | High selects zero extension for loads |
| addr_lo_i | input | 2 | Low byte-address bits of the access |
| load_i | input | 1 | Load request this cycle |
| store_i | input | 1 | Store request this cycle |
| rdata_i | input | 32 | Word read from data memory |
| wdata_i | input | 32 | Source register value for stores |
| mem_wdata_o | output | 32 | Lane-replicated write data to memory |
| mem_be_o | output | 4 | Per-byte write enables, bit 3 = bits 31:24 |
| misalign_o | output | 1 | Access violates its natural alignment |
| load_data_o | output | 32 | Aligned and extended load result |
| load_valid_o | output | 1 | load_data_o holds an aligned load result |

## Verification
The assertions that look at the registered load result compare it with the request seen one edge earlier. They therefore assume that the size, extension select and load request are stable around each rising edge and that all inputs stay idle while reset is held. The bench changes inputs only on falling edges and holds load_i, store_i and the other controls low throughout reset. The checks on lanes and enables assume that only the low address bits reach the block. The stimulus therefore covers every offset with every size code, including the reserved one, and sometimes raises load and store together.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsa_misalign.sv
module lsa_misalign
  import lsa_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [1:0]       size_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             req_i,
  output logic             bad_o
);
  logic hit;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: hit = 1'b0;
      SZ_HALF: hit = off_i[0];
      SZ_WORD: hit = |off_i;
      default: hit = 1'b1;  // reserved code is always rejected
    endcase
  end

  assign bad_o = req_i & hit;
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int HALVES = BYTES / 2,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic [7:0]  lane  [BYTES];
  logic [15:0] hlane [HALVES];
  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  logic        sx;

  // big-endian: offset 0 is the most significant lane
  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign lane[k] = rdata_i[DATA_W-1-8*k -: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_hlane
    assign hlane[h] = rdata_i[DATA_W-1-16*h -: 16];
  end

  assign byte_sel = lane[off_i];
  assign half_sel = hlane[off_i[OFF_W-1:1]];
  assign sx       = ~unsigned_i;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: data_o = {{(DATA_W-8){sx & byte_sel[7]}}, byte_sel};
      SZ_HALF: data_o = {{(DATA_W-16){sx & half_sel[15]}}, half_sel};
      SZ_WORD: data_o = rdata_i;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/lsa_store_pack.sv
module lsa_store_pack
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int HALVES = BYTES / 2,
  localparam int OFF_W  = $clog2(BYTES)
) (
  input  logic [1:0]        size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [BYTES-1:0]  be_o
);
  logic [BYTES-1:0] byte_be;
  logic [BYTES-1:0] half_be;

  always_comb begin
    byte_be = '0;
    half_be = '0;
    for (int k = 0; k < BYTES; k++) begin
      byte_be[BYTES-1-k] = (off_i == OFF_W'(k));
    end
    for (int h = 0; h < HALVES; h++) begin
      half_be[BYTES-1-2*h] = (off_i[OFF_W-1:1] == (OFF_W-1)'(h));
      half_be[BYTES-2-2*h] = (off_i[OFF_W-1:1] == (OFF_W-1)'(h));
    end
  end

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: begin
        wdata_o = {BYTES{wdata_i[7:0]}};
        be_o    = en_i ? byte_be : '0;
      end
      SZ_HALF: begin
        wdata_o = {HALVES{wdata_i[15:0]}};
        be_o    = en_i ? half_be : '0;
      end
      SZ_WORD: begin
        wdata_o = wdata_i;
        be_o    = en_i ? '1 : '0;
      end
      default: begin
        wdata_o = wdata_i;
        be_o    = '0;
      end
    endcase
  end
endmodule

// File: rtl/ldst_lane_align.sv
module ldst_lane_align
  import lsa_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit REG_LOAD = 1'b1,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic              load_i,
  input  logic              store_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [BYTES-1:0]  mem_be_o,
  output logic              misalign_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              load_valid_o
);
  logic              bad;
  logic              ld_ok;
  logic              st_ok;
  logic [DATA_W-1:0] ld_ext;
  logic [DATA_W-1:0] ld_comb;

  lsa_misalign #(.OFF_W(OFF_W)) u_mis (
    .size_i (size_i),
    .off_i  (addr_lo_i),
    .req_i  (load_i | store_i),
    .bad_o  (bad)
  );

  lsa_load_extract #(.DATA_W(DATA_W)) u_ld (
    .size_i     (size_i),
    .unsigned_i (unsigned_i),
    .off_i      (addr_lo_i),
    .rdata_i    (rdata_i),
    .data_o     (ld_ext)
  );

  assign st_ok = store_i & ~bad;

  lsa_store_pack #(.DATA_W(DATA_W)) u_st (
    .size_i  (size_i),
    .off_i   (addr_lo_i),
    .en_i    (st_ok),
    .wdata_i (wdata_i),
    .wdata_o (mem_wdata_o),
    .be_o    (mem_be_o)
  );

  assign misalign_o = bad;
  assign ld_ok      = load_i & ~bad;
  assign ld_comb    = ld_ok ? ld_ext : '0;

  if (REG_LOAD) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        load_data_o  <= '0;
        load_valid_o <= 1'b0;
      end else begin
        load_data_o  <= ld_comb;
        load_valid_o <= ld_ok;
      end
    end
  end else begin : g_comb
    assign load_data_o  = ld_comb;
    assign load_valid_o = ld_ok;
  end
endmodule

// File: rtl/lsa_align_chk.sv
module lsa_align_chk #(
  parameter int DATA_W   = 32,
  parameter bit REG_LOAD = 1'b1,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        size_i,
  input logic              unsigned_i,
  input logic [OFF_W-1:0]  addr_lo_i,
  input logic              load_i,
  input logic              store_i,
  input logic [BYTES-1:0]  mem_be_o,
  input logic              misalign_o,
  input logic [DATA_W-1:0] load_data_o,
  input logic              load_valid_o
);
  logic       armed;
  logic       ok_q;
  logic [1:0] size_q;
  logic       uns_q;

  if (REG_LOAD) begin : g_q
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        armed  <= 1'b0;
        ok_q   <= 1'b0;
        size_q <= '0;
        uns_q  <= 1'b0;
      end else begin
        armed  <= 1'b1;
        ok_q   <= load_i & ~misalign_o;
        size_q <= size_i;
        uns_q  <= unsigned_i;
      end
    end
  end else begin : g_d
    assign armed  = 1'b1;
    assign ok_q   = load_i & ~misalign_o;
    assign size_q = size_i;
    assign uns_q  = unsigned_i;
  end

  // R7
  be_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !store_i |-> mem_be_o == '0);

  // R9
  be_misalign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misalign_o |-> mem_be_o == '0);

  // R7
  byte_one_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && size_i == 2'b00) |-> $countones(mem_be_o) == 1);

  // R8
  byte_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i == 2'b00 |-> !misalign_o);

  // R8
  word_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((load_i || store_i) && size_i == 2'b10 && addr_lo_i != '0) |-> misalign_o);

  // R5
  load_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> load_valid_o == ok_q);

  // R9
  load_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !ok_q) |-> load_data_o == '0);

  // R3
  byte_zext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ok_q && size_q == 2'b00 && uns_q) |-> load_data_o[DATA_W-1:8] == '0);

  // R3
  byte_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ok_q && size_q == 2'b00 && !uns_q)
      |-> load_data_o[DATA_W-1:8] == {(DATA_W-8){load_data_o[7]}});
endmodule

bind ldst_lane_align lsa_align_chk #(
  .DATA_W   (DATA_W),
  .REG_LOAD (REG_LOAD)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .size_i       (size_i),
  .unsigned_i   (unsigned_i),
  .addr_lo_i    (addr_lo_i),
  .load_i       (load_i),
  .store_i      (store_i),
  .mem_be_o     (mem_be_o),
  .misalign_o   (misalign_o),
  .load_data_o  (load_data_o),
  .load_valid_o (load_valid_o)
);

// File: tb/ldst_lane_align_test.sv
module ldst_lane_align_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  size_i = '0;
  logic        unsigned_i = 1'b0;
  logic [1:0]  addr_lo_i = '0;
  logic        load_i = 1'b0;
  logic        store_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] mem_wdata_o;
  logic [3:0]  mem_be_o;
  logic        misalign_o;
  logic [31:0] load_data_o;
  logic        load_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic        v;
    logic [31:0] d;
    int          sz;
    logic        bad;
  } exp_t;
  exp_t exp_q[$];

  ldst_lane_align uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .size_i(size_i), .unsigned_i(unsigned_i),
    .addr_lo_i(addr_lo_i), .load_i(load_i), .store_i(store_i),
    .rdata_i(rdata_i), .wdata_i(wdata_i), .mem_wdata_o(mem_wdata_o),
    .mem_be_o(mem_be_o), .misalign_o(misalign_o),
    .load_data_o(load_data_o), .load_valid_o(load_valid_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_bad(int sz, int off, bit req);
    bit h;
    h = (sz == 3) || (sz == 1 && (off % 2) == 1) || (sz == 2 && off != 0);
    return req && h;
  endfunction

  // one request: drive at falling edge, check combinational outputs, then the registered load
  task automatic step(int sz, bit uns, int off, bit ld, bit st, logic [31:0] rd, logic [31:0] wd);
    exp_t e;
    bit bad;
    logic [3:0] be;
    logic [31:0] wexp;
    logic [7:0] b;
    logic [15:0] h;
    @(negedge clk_i);
    size_i = 2'(sz); unsigned_i = uns; addr_lo_i = 2'(off);
    load_i = ld; store_i = st; rdata_i = rd; wdata_i = wd;
    #2;
    bad = is_bad(sz, off, ld || st);
    chk("R8 misalign", {31'd0, misalign_o}, {31'd0, bad});
    be = 4'h0;
    if (st && !bad) begin
      if (sz == 0) be = 4'(1 << (3 - off));
      else if (sz == 1) be = (off == 0) ? 4'hC : 4'h3;
      else be = 4'hF;
    end
    if (st && bad) chk("R9 store suppressed", {28'd0, mem_be_o}, {28'd0, be});
    else chk("R7 byte enables", {28'd0, mem_be_o}, {28'd0, be});
    if (st && !bad) begin
      if (sz == 0) wexp = {4{wd[7:0]}};
      else if (sz == 1) wexp = {2{wd[15:0]}};
      else wexp = wd;
      chk("R6 store data", mem_wdata_o, wexp);
    end
    e.v = ld && !bad; e.sz = sz; e.bad = bad; e.d = 32'h0;
    if (e.v) begin
      if (sz == 0) begin
        b = rd[8*(3-off) +: 8];
        e.d = {(uns ? 24'h0 : {24{b[7]}}), b};
      end else if (sz == 1) begin
        h = rd[8*(2-off) +: 16];
        e.d = {(uns ? 16'h0 : {16{h[15]}}), h};
      end else e.d = rd;
    end
    exp_q.push_back(e);
    @(posedge clk_i);
    #2;
    e = exp_q.pop_front();
    chk("R5 load valid", {31'd0, load_valid_o}, {31'd0, e.v});
    if (!e.v) chk("R9 no load data", load_data_o, e.d);
    else if (e.sz == 0) begin
      chk("R1 byte lane", {24'd0, load_data_o[7:0]}, {24'd0, e.d[7:0]});
      chk("R3 byte extension", {8'd0, load_data_o[31:8]}, {8'd0, e.d[31:8]});
    end else if (e.sz == 1) begin
      chk("R2 halfword lane", {16'd0, load_data_o[15:0]}, {16'd0, e.d[15:0]});
      chk("R3 halfword extension", {16'd0, load_data_o[31:16]}, {16'd0, e.d[31:16]});
    end else chk("R4 word load", load_data_o, e.d);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    chk("R5 reset data", load_data_o, 32'h0);
    chk("R5 reset valid", {31'd0, load_valid_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // byte loads, every offset, both extensions
    for (int o = 0; o < 4; o++) begin
      step(0, 1'b0, o, 1'b1, 1'b0, 32'h807F01FE, 32'h0);
      step(0, 1'b1, o, 1'b1, 1'b0, 32'h807F01FE, 32'h0);
    end
    // halfword loads
    step(1, 1'b0, 0, 1'b1, 1'b0, 32'h80017FFE, 32'h0);
    step(1, 1'b1, 0, 1'b1, 1'b0, 32'h80017FFE, 32'h0);
    step(1, 1'b0, 2, 1'b1, 1'b0, 32'h7FFE8001, 32'h0);
    step(1, 1'b0, 2, 1'b1, 1'b0, 32'h80017FFE, 32'h0);
    step(2, 1'b0, 0, 1'b1, 1'b0, 32'hDEADBEEF, 32'h0);
    // misaligned and reserved
    step(1, 1'b0, 1, 1'b1, 1'b0, 32'hFFFFFFFF, 32'h0);
    step(1, 1'b0, 3, 1'b0, 1'b1, 32'h0, 32'h12345678);
    for (int o = 1; o < 4; o++) step(2, 1'b0, o, 1'b1, 1'b1, 32'hA5A5A5A5, 32'h5A5A5A5A);
    step(3, 1'b0, 0, 1'b1, 1'b1, 32'h11111111, 32'h22222222);
    // stores
    for (int o = 0; o < 4; o++) step(0, 1'b0, o, 1'b0, 1'b1, 32'h0, 32'hCAFE12AB);
    step(1, 1'b0, 0, 1'b0, 1'b1, 32'h0, 32'hCAFE12AB);
    step(1, 1'b0, 2, 1'b0, 1'b1, 32'h0, 32'hCAFE12AB);
    step(2, 1'b0, 0, 1'b0, 1'b1, 32'h0, 32'hCAFE12AB);
    // idle cycle: no enables, no load
    step(0, 1'b0, 0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    for (int i = 0; i < 3000; i++) begin
      step(int'($urandom_range(3)), 1'($urandom_range(1)), int'($urandom_range(3)),
           1'($urandom_range(1)), 1'($urandom_range(1)), $urandom, $urandom);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule